// File: doc/BRIEF.md
# Display Reset Pulse Train Generator

This block drives the active-low reset line of an attached display panel. Software writes one control word that holds a pulse width, a pulse count and a start bit. The block then produces a burst of equal low pulses, with a high gap of the same length between each pair. When the last pulse returns high, it raises a done flag. Software clears that flag by writing a one to a clear input.

Pulse width is counted in ticks of a power-of-two prescaler that runs from the module clock. The exponent comes from a ratio input and is captured when the sequence starts. A reset period that is longer than one pulse can reach is built by asking for several pulses.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst` is high and after it is released, `disp_rst_n` is 1 and `done` is 0 until a sequence is started.
- R2: A control write with `ctl_start`=1 while idle drives `disp_rst_n` low from the cycle after the write edge. The pulse lasts exactly (`ctl_width`+1)·2^`tick_ratio` clock cycles. The prescaler restarts from zero on every start.
- R3: A sequence produces exactly `ctl_count`+1 low pulses.
- R4: Consecutive pulses are separated by a high gap of the same length as one pulse. No gap follows the last pulse.
- R5: `done` reads 1 from the first cycle in which `disp_rst_n` returns high after the last pulse, and stays 1 until it is cleared.
- R6: A write with `clr_we`=1 and `clr_done`=1 clears `done` on the next cycle. A write with `clr_done`=0 leaves `done` unchanged.
- R7: A control write with `ctl_start`=1 during a running sequence is ignored. The width, count, ratio and timing of the running burst are not changed.
- R8: A control write with `ctl_start`=0 starts nothing. `disp_rst_n` stays high.
- R9: Starting a new sequence clears `done` in the cycle after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_width | input | WIDTH_W | Pulse width minus one, in ticks |
| ctl_count | input | COUNT_W | Pulse count minus one |
| ctl_start | input | 1 | Start bit of the control word |
| tick_ratio | input | RATIO_W | Prescaler exponent: one tick is 2^ratio clocks |
| clr_we | input | 1 | Status clear write strobe |
| clr_done | input | 1 | Write one to clear `done` |
| disp_rst_n | output | 1 | Display reset, active low, idles high |
| done | output | 1 | Raw sequence-finished flag |

## Verification
The bench builds the block with its default parameters: a 6-bit width, a 3-bit count and a 4-bit ratio. The random stimulus keeps the ratio at 3 or below and the width at 7 or below, so that many complete bursts fit in the run and can be compared cycle by cycle. Directed cases cover the remaining range: the single one-cycle pulse, the full width of 63, the maximum count of 7, and a larger ratio. Each burst is checked against a waveform computed from the width, count and ratio. Starts written in the middle of a burst, clears written with a zero, and restarts while `done` is set are also checked.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int WIDTH_W = 6,
  parameter int COUNT_W = 3,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [WIDTH_W-1:0] ctl_width,
  input  logic [COUNT_W-1:0] ctl_count,
  input  logic               ctl_start,
  input  logic [RATIO_W-1:0] tick_ratio,
  input  logic               clr_we,
  input  logic               clr_done,
  output logic               disp_rst_n,
  output logic               done
);

  localparam int PRE_W = 2 ** RATIO_W;

  logic               run, low_ph;
  logic [PRE_W-1:0]   presc, mask;
  logic [WIDTH_W-1:0] tcnt, wid_q;
  logic [COUNT_W-1:0] pcnt, cnt_q;
  logic [RATIO_W-1:0] rat_q;
  logic               tick, phase_end, finish, start_ok;

  assign mask      = (PRE_W'(1) << rat_q) - PRE_W'(1);
  assign tick      = run && (presc == mask);
  assign phase_end = tick && (tcnt == wid_q);
  assign finish    = phase_end && low_ph && (pcnt == cnt_q);
  assign start_ok  = ctl_we && ctl_start && !run;
  assign disp_rst_n = !(run && low_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      low_ph <= 1'b0;
      presc  <= '0;
      tcnt   <= '0;
      pcnt   <= '0;
      wid_q  <= '0;
      cnt_q  <= '0;
      rat_q  <= '0;
    end else if (start_ok) begin
      run    <= 1'b1;
      low_ph <= 1'b1;
      presc  <= '0;
      tcnt   <= '0;
      pcnt   <= '0;
      wid_q  <= ctl_width;
      cnt_q  <= ctl_count;
      rat_q  <= tick_ratio;
    end else if (run) begin
      presc <= tick ? '0 : presc + PRE_W'(1);
      if (tick) tcnt <= phase_end ? '0 : tcnt + WIDTH_W'(1);
      if (finish) begin
        run    <= 1'b0;
        low_ph <= 1'b0;
      end else if (phase_end) begin
        if (!low_ph) pcnt <= pcnt + COUNT_W'(1);
        low_ph <= !low_ph;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     done <= 1'b0;
    else if (finish)             done <= 1'b1;
    else if (start_ok)           done <= 1'b0;
    else if (clr_we && clr_done) done <= 1'b0;
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> !disp_rst_n && !done);
  p_presc_range_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> presc <= mask);
  p_pulse_index_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> pcnt <= cnt_q);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> disp_rst_n && !run);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_we && clr_done && !finish |=> !done);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    run && ctl_we && ctl_start |=> run && $stable(wid_q) && $stable(cnt_q) && $stable(rat_q));
  p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
    !run |-> disp_rst_n);

endmodule

// File: tb/tb_rst_pulse_gen.sv
module tb_rst_pulse_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0, ctl_start = 1'b0, clr_we = 1'b0, clr_done = 1'b0;
  logic [5:0] ctl_width = '0;
  logic [2:0] ctl_count = '0;
  logic [3:0] tick_ratio = '0;
  logic       disp_rst_n, done;
  int         n_cmp = 0, n_bad = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  rst_pulse_gen dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_width(ctl_width),
    .ctl_count(ctl_count), .ctl_start(ctl_start), .tick_ratio(tick_ratio),
    .clr_we(clr_we), .clr_done(clr_done), .disp_rst_n(disp_rst_n), .done(done)
  );

  function automatic int pulse_len(int w, int r);
    return (w + 1) * (1 << r);
  endfunction

  function automatic logic exp_out(int k, int w, int n, int r);
    int l = pulse_len(w, r);
    int t = (2 * (n + 1) - 1) * l;
    if (k >= t) return 1'b1;
    return ((k / l) % 2) != 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Start a burst; optionally write a conflicting start at cycle mid (R7)
  task automatic run_seq(int w, int n, int r, int mid);
    int t = (2 * (n + 1) - 1) * pulse_len(w, r);
    ctl_we = 1'b1; ctl_start = 1'b1;
    ctl_width = 6'(w); ctl_count = 3'(n); tick_ratio = 4'(r);
    for (int k = 0; k <= t + 2; k++) begin
      @(negedge clk);
      ctl_we = 1'b0;
      if (k == 0) check("R9 done cleared by start", done, 1'b0);
      check((k / pulse_len(w, r)) % 2 == 0 ? "R2/R3 pulse" : "R4 gap",
            disp_rst_n, exp_out(k, w, n, r));
      check("R5 done", done, k >= t);
      if (k == mid && k + 2 < t) begin
        ctl_we = 1'b1; ctl_start = 1'b1;
        ctl_width = 6'(w ^ 5); ctl_count = 3'(n ^ 3); tick_ratio = 4'(r ^ 1);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset out", disp_rst_n, 1'b1);
    check("R1 reset done", done, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset out", disp_rst_n, 1'b1);
    check("R1 post-reset done", done, 1'b0);

    // R8: write without start
    ctl_we = 1'b1; ctl_start = 1'b0; ctl_width = 6'd2;
    @(negedge clk);
    ctl_we = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8 no start", disp_rst_n, 1'b1);
    end

    // directed corners
    run_seq(0, 0, 0, -1);
    // R6: clear with zero keeps done, clear with one drops it
    clr_we = 1'b1; clr_done = 1'b0;
    @(negedge clk);
    clr_we = 1'b0;
    check("R6 clear zero ignored", done, 1'b1);
    clr_we = 1'b1; clr_done = 1'b1;
    @(negedge clk);
    clr_we = 1'b0; clr_done = 1'b0;
    check("R6 clear one", done, 1'b0);
    @(negedge clk);
    check("R6 stays clear", done, 1'b0);

    run_seq(0, 7, 0, 3);
    run_seq(63, 0, 0, 10);
    run_seq(3, 1, 5, 50);
    run_seq(0, 0, 0, -1);

    for (int i = 0; i < 40; i++) begin
      int w = $urandom_range(7, 0);
      int n = $urandom_range(7, 0);
      int r = $urandom_range(3, 0);
      int m = $urandom_range(20, 0);
      repeat ($urandom_range(3, 0)) @(negedge clk);
      if ($urandom_range(1, 0) == 1) begin
        clr_we = 1'b1; clr_done = 1'b1;
        @(negedge clk);
        clr_we = 1'b0; clr_done = 1'b0;
        check("R6 random clear", done, 1'b0);
      end
      run_seq(w, n, r, m);
    end
    summary();
  end
endmodule